// File: doc/BRIEF.md
# Segmented RAM Sweep Controller

This block owns a single-port sweep memory, 1024 words of 32 bits by default, and walks its read address to feed a frequency or phase sweep into a synthesizer core. The memory is split into four segments. Each segment holds a start address, an end address, a 16-bit dwell count and a 3-bit sweep mode. A 2-bit profile input picks the active segment. Every cycle the block is enabled, it reads the word at the current address and presents it with a valid flag.

A load port writes words into the memory and takes priority over the sweep read. A write cycle cancels that cycle's read. The address advances by one whenever a dwell counter, reloaded from the segment's dwell count, runs out. Depending on the mode, the address holds, climbs and stops, follows a direction line, bounces between the bounds, or wraps back to the start. Changing the profile drops the running sweep at once and starts the new segment from its start address. The one exception is the direction-driven mode held in segment 0, where the profile only steers.

Top module: `ram_sweep_ctrl`

## Requirements
- R1: After reset, cur_addr is 0, rd_valid is 0 and rd_data is 0.
- R2: In a cycle with wr_en high, wr_data is stored at wr_addr and no read happens, so rd_valid is 0 after that edge even when ram_en is high.
- R3: In a cycle with ram_en high and wr_en low, rd_valid is 1 after the edge and rd_data equals the stored word at the cur_addr value seen just before that edge.
- R4: While ram_en is low, rd_valid is 0 and cur_addr and the dwell counter hold. A rising ram_en restarts the active segment at its start address.
- R5: When the profile changes while ram_en is high (outside the locked case of R9), cur_addr is loaded with the new segment's start address on that edge, and the dwell counter is reloaded.
- R6: With dwell count D (0 counts as 1), the address takes its n-th step on the n*D-th edge after the restart edge.
- R7: Mode code 0 (hold) keeps cur_addr at the start address.
- R8: Mode code 1 (climb) steps up by one and then stays at the end address.
- R9: When segment 0 carries mode code 2 (steer), segment 0 is used whatever the profile is. Profile bit 0 high steps toward the end address and low steps toward the start address, stopping at the bound. A profile change then does not restart the sweep.
- R10: Mode code 3 (bounce) climbs to the end address, then descends to the start address, and repeats, with period 2*(end-start) steps.
- R11: Mode code 4 (wrap) climbs to the end address and then jumps to the start address on the next step, with period (end-start+1) steps.
- R12: Mode codes 5 to 7 behave like mode code 0.
- R13: A cycle with cfg_we high stores cfg_start, cfg_end, cfg_rate and cfg_mode for segment cfg_seg. All segment fields reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_en | input | 1 | Enables sweep reads and address stepping |
| profile | input | 2 | Segment select; bit 0 is also the direction line in steer mode |
| cfg_we | input | 1 | Segment configuration write strobe |
| cfg_seg | input | 2 | Segment written by cfg_we |
| cfg_start | input | 10 | Start address to store |
| cfg_end | input | 10 | End address to store |
| cfg_rate | input | 16 | Dwell count to store |
| cfg_mode | input | 3 | Mode code to store |
| wr_en | input | 1 | Memory write strobe, priority over reads |
| wr_addr | input | 10 | Memory write address |
| wr_data | input | 32 | Memory write data |
| rd_data | output | 32 | Word read at the sweep address |
| rd_valid | output | 1 | rd_data was read on the last edge |
| cur_addr | output | 10 | Current sweep address |

## Verification
The bench targets the turning points of each mode. In climb mode, a design that overshoots the end address reads past the segment. In bounce mode, a reversal that is off by one repeats or skips the end word. In wrap mode, a wrong wrap either lands on start+1 or lingers on the end word. It also checks the edge on which a profile change restarts. If the dwell counter is not reloaded there, the first step comes early. It covers the locked steer case, where a design that restarts on a profile change snaps back to the start address instead of reversing. Finally, it checks that a write cancels a read. A design that lets the two collide would report a valid word in the write cycle.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  localparam logic [2:0] MODE_HOLD   = 3'd0;
  localparam logic [2:0] MODE_CLIMB  = 3'd1;
  localparam logic [2:0] MODE_STEER  = 3'd2;
  localparam logic [2:0] MODE_BOUNCE = 3'd3;
  localparam logic [2:0] MODE_WRAP   = 3'd4;

  // Dwell count of zero is treated as one so the address still moves.
  function automatic logic [15:0] eff_dwell(input logic [15:0] d);
    return (d == 16'd0) ? 16'd1 : d;
  endfunction
endpackage

// File: rtl/seg_cfg_bank.sv
module seg_cfg_bank #(
  parameter int SEGS   = 4,
  parameter int ADDR_W = 10,
  parameter int RATE_W = 16,
  localparam int SEL_W = $clog2(SEGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  wseg,
  input  logic [ADDR_W-1:0] wstart,
  input  logic [ADDR_W-1:0] wend,
  input  logic [RATE_W-1:0] wrate,
  input  logic [2:0]        wmode,
  input  logic [SEL_W-1:0]  sel,
  output logic [ADDR_W-1:0] sel_start,
  output logic [ADDR_W-1:0] sel_end,
  output logic [RATE_W-1:0] sel_rate,
  output logic [2:0]        sel_mode,
  output logic [2:0]        seg0_mode
);
  logic [ADDR_W-1:0] start_q [SEGS];
  logic [ADDR_W-1:0] end_q   [SEGS];
  logic [RATE_W-1:0] rate_q  [SEGS];
  logic [2:0]        mode_q  [SEGS];

  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        start_q[g] <= '0;
        end_q[g]   <= '0;
        rate_q[g]  <= '0;
        mode_q[g]  <= '0;
      end else if (we && wseg == SEL_W'(g)) begin
        start_q[g] <= wstart;
        end_q[g]   <= wend;
        rate_q[g]  <= wrate;
        mode_q[g]  <= wmode;
      end
    end
  end

  assign sel_start = start_q[sel];
  assign sel_end   = end_q[sel];
  assign sel_rate  = rate_q[sel];
  assign sel_mode  = mode_q[sel];
  assign seg0_mode = mode_q[0];
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
  import sweep_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int RATE_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_en,
  input  logic [SEL_W-1:0]  profile,
  input  logic              steer_lock,
  input  logic [ADDR_W-1:0] seg_start,
  input  logic [ADDR_W-1:0] seg_end,
  input  logic [RATE_W-1:0] seg_rate,
  input  logic [2:0]        seg_mode,
  output logic [ADDR_W-1:0] addr,
  output logic              restart,
  output logic              step_ev
);
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
  localparam logic [RATE_W-1:0] T_ONE = RATE_W'(1);

  logic [RATE_W-1:0] timer;
  logic [RATE_W-1:0] dwell;
  logic              dir_up;
  logic              en_q;
  logic [SEL_W-1:0]  prof_q;
  logic [ADDR_W-1:0] nxt_addr;
  logic              nxt_dir;

  assign dwell   = RATE_W'(eff_dwell(16'(seg_rate)));
  assign restart = ram_en && (!en_q || (!steer_lock && profile != prof_q));
  assign step_ev = ram_en && !restart && (timer <= T_ONE);

  always_comb begin
    nxt_addr = addr;
    nxt_dir  = dir_up;
    case (seg_mode)
      MODE_CLIMB:  if (addr < seg_end) nxt_addr = addr + A_ONE;
      MODE_STEER: begin
        if (profile[0]) begin
          if (addr < seg_end) nxt_addr = addr + A_ONE;
        end else if (addr > seg_start) nxt_addr = addr - A_ONE;
      end
      MODE_BOUNCE: begin
        if (seg_end > seg_start) begin
          if (dir_up) begin
            if (addr >= seg_end) begin nxt_addr = addr - A_ONE; nxt_dir = 1'b0; end
            else nxt_addr = addr + A_ONE;
          end else begin
            if (addr <= seg_start) begin nxt_addr = addr + A_ONE; nxt_dir = 1'b1; end
            else nxt_addr = addr - A_ONE;
          end
        end
      end
      MODE_WRAP:   nxt_addr = (addr >= seg_end) ? seg_start : addr + A_ONE;
      default:     nxt_addr = seg_start;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      timer  <= '0;
      dir_up <= 1'b1;
      en_q   <= 1'b0;
      prof_q <= '0;
    end else begin
      en_q   <= ram_en;
      prof_q <= profile;
      if (restart) begin
        addr   <= seg_start;
        timer  <= dwell;
        dir_up <= 1'b1;
      end else if (step_ev) begin
        addr   <= nxt_addr;
        timer  <= dwell;
        dir_up <= nxt_dir;
      end else if (ram_en) begin
        timer  <= timer - T_ONE;
      end
    end
  end

  // R5: a restart lands on the segment start
  p_restart_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> addr == $past(seg_start));
  // R6 / R4: address only moves on a step or restart
  p_still_between_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !step_ev) |=> $stable(addr));
  // R7: hold mode stays on the start address
  p_hold_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && en_q && !restart && seg_mode == MODE_HOLD) |-> addr == seg_start);
  // R8: climb never passes the end address
  p_climb_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && en_q && !restart && seg_mode == MODE_CLIMB) |-> addr <= seg_end);
  // R11: wrap from the end lands on start
  p_wrap_to_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && seg_mode == MODE_WRAP && addr == seg_end) |=> addr == $past(seg_start));
endmodule

// File: rtl/sweep_ram_port.sv
module sweep_ram_port #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              rd_go;

  // Write wins the single port; a colliding read is dropped.
  assign rd_go = ram_en && !wr_en;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) rd_data <= mem[rd_addr];
    end
  end

  p_write_drops_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rd_valid);
  p_idle_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_en |=> !rd_valid);
  p_read_when_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !wr_en) |=> rd_valid);
endmodule

// File: rtl/ram_sweep_ctrl.sv
module ram_sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int SEGS   = 4,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int RATE_W = 16,
  localparam int SEL_W = $clog2(SEGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_en,
  input  logic [SEL_W-1:0]  profile,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_seg,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic [ADDR_W-1:0] cfg_end,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic [2:0]        cfg_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0] s_start, s_end;
  logic [RATE_W-1:0] s_rate;
  logic [2:0]        s_mode, m0;
  logic              steer_lock;
  logic [SEL_W-1:0]  sel;
  logic              restart, step_ev;

  // Steer mode in segment 0 pins the selection; profile only steers.
  assign steer_lock = (m0 == MODE_STEER);
  assign sel        = steer_lock ? '0 : profile;

  seg_cfg_bank #(.SEGS(SEGS), .ADDR_W(ADDR_W), .RATE_W(RATE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wseg(cfg_seg),
    .wstart(cfg_start), .wend(cfg_end), .wrate(cfg_rate), .wmode(cfg_mode),
    .sel(sel), .sel_start(s_start), .sel_end(s_end), .sel_rate(s_rate),
    .sel_mode(s_mode), .seg0_mode(m0));

  sweep_seq #(.ADDR_W(ADDR_W), .RATE_W(RATE_W), .SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ram_en(ram_en), .profile(profile),
    .steer_lock(steer_lock), .seg_start(s_start), .seg_end(s_end),
    .seg_rate(s_rate), .seg_mode(s_mode), .addr(cur_addr),
    .restart(restart), .step_ev(step_ev));

  sweep_ram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .ram_en(ram_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(cur_addr),
    .rd_data(rd_data), .rd_valid(rd_valid));

  // R9: under the steer lock a profile change never restarts
  p_steer_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (steer_lock && ram_en && $past(ram_en)) |-> !restart);
endmodule

// File: tb/ram_sweep_ctrl_tb_top.sv
`timescale 1ns/1ps
module ram_sweep_ctrl_tb_top;
  logic clk = 0, rst_n = 0, ram_en = 0, cfg_we = 0, wr_en = 0;
  logic [1:0] profile = 0, cfg_seg = 0;
  logic [9:0] cfg_start = 0, cfg_end = 0, wr_addr = 0;
  logic [15:0] cfg_rate = 0;
  logic [2:0] cfg_mode = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic rd_valid;
  logic [9:0] cur_addr;
  int n_chk = 0, n_fail = 0;
  logic [31:0] model [1024];
  logic [9:0] last_addr = 0;
  bit mon_on = 0;

  always #2.5 clk = ~clk;

  ram_sweep_ctrl dut_i (.clk(clk), .rst_n(rst_n), .ram_en(ram_en), .profile(profile),
    .cfg_we(cfg_we), .cfg_seg(cfg_seg), .cfg_start(cfg_start), .cfg_end(cfg_end),
    .cfg_rate(cfg_rate), .cfg_mode(cfg_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .cur_addr(cur_addr));

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic int exp_addr(input int mode, input int s, input int e, input int r, input int k);
    int n, len;
    n = k / ((r == 0) ? 1 : r);
    len = e - s;
    case (mode)
      1: return (s + n > e) ? e : s + n;
      3: begin
        if (len == 0) return s;
        n = n % (2 * len);
        return (n <= len) ? s + n : e - (n - len);
      end
      4: return s + (n % (len + 1));
      default: return s;
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R3: every valid read matches the model at the address seen before the edge
  always @(negedge clk) begin
    if (mon_on && rd_valid) check("R3", rd_data, model[last_addr]);
    last_addr = cur_addr;
  end

  task automatic cfg(input int seg, input int s, input int e, input int r, input int m);
    @(negedge clk);
    cfg_we = 1; cfg_seg = 2'(seg); cfg_start = 10'(s); cfg_end = 10'(e);
    cfg_rate = 16'(r); cfg_mode = 3'(m);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic mem_write(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 10'(a); wr_data = d;
    @(posedge clk); #1 model[a] = d; wr_en = 0;
  endtask

  // Enable with a profile, let k edges pass after the restart edge, check address.
  task automatic run(input string req, input int seg, input int mode, input int s,
                     input int e, input int r, input int k);
    @(negedge clk); profile = 2'(seg); ram_en = 1;
    @(posedge clk);
    repeat (k) @(posedge clk);
    @(negedge clk);
    check(req, cur_addr, exp_addr(mode, s, e, r, k));
    ram_en = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 addr", cur_addr, 0);
    check("R1 valid", rd_valid, 0);
    check("R1 data", rd_data, 0);
    rst_n = 1;
    for (int a = 0; a < 1024; a++) mem_write(a, pat(a));
    @(negedge clk);
    check("R4 idle valid", rd_valid, 0);
    mon_on = 1;

    cfg(1, 10, 14, 2, 1);                          // R13 config, R8 climb
    run("R8 mid", 1, 1, 10, 14, 2, 5);
    run("R8 end hold", 1, 1, 10, 14, 2, 40);
    cfg(2, 100, 200, 3, 0);
    run("R7 hold", 2, 0, 100, 200, 3, 30);
    cfg(2, 300, 310, 1, 5);
    run("R12 reserved", 2, 5, 300, 310, 1, 25);
    cfg(3, 500, 505, 1, 3);
    run("R10 bounce turn", 3, 3, 500, 505, 1, 6);
    run("R10 bounce back", 3, 3, 500, 505, 1, 10);
    run("R10 bounce rise", 3, 3, 500, 505, 1, 11);
    cfg(3, 600, 603, 2, 4);
    run("R11 wrap end", 3, 4, 600, 603, 2, 7);
    run("R11 wrap start", 3, 4, 600, 603, 2, 8);
    cfg(1, 20, 60, 0, 1);
    run("R6 dwell zero", 1, 1, 20, 60, 0, 9);
    cfg(1, 20, 60, 4, 1);
    run("R6 dwell four pre", 1, 1, 20, 60, 4, 7);
    run("R6 dwell four", 1, 1, 20, 60, 4, 8);

    // R5 profile change mid-sweep
    cfg(3, 700, 720, 3, 4);
    @(negedge clk); profile = 1; ram_en = 1;
    repeat (12) @(negedge clk);
    profile = 3;
    @(posedge clk); repeat (4) @(posedge clk);
    @(negedge clk);
    check("R5 restart", cur_addr, exp_addr(4, 700, 720, 3, 4));
    // R4 disable holds address
    ram_en = 0;
    begin
      logic [9:0] held;
      held = cur_addr;
      repeat (5) @(negedge clk);
      check("R4 hold addr", cur_addr, held);
      check("R4 no valid", rd_valid, 0);
    end

    // R2 write priority while reading
    cfg(2, 40, 60, 1, 0);
    @(negedge clk); profile = 2; ram_en = 1;
    repeat (3) @(negedge clk);
    @(negedge clk); wr_en = 1; wr_addr = 10'd40; wr_data = 32'hCAFE_F00D;
    @(posedge clk); #1 model[40] = 32'hCAFE_F00D; wr_en = 0;
    @(negedge clk);
    check("R2 read dropped", rd_valid, 0);
    @(negedge clk);
    check("R2 valid after", rd_valid, 1);
    check("R2 new data", rd_data, 32'hCAFE_F00D);
    ram_en = 0;
    @(negedge clk);

    // R9 steer mode in segment 0
    cfg(0, 40, 45, 1, 2);
    @(negedge clk); profile = 2'b11; ram_en = 1;
    @(posedge clk); repeat (8) @(posedge clk);
    @(negedge clk);
    check("R9 up to end", cur_addr, 45);
    profile = 2'b10;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R9 reverse no restart", cur_addr, 43);
    repeat (10) @(negedge clk);
    check("R9 hold start", cur_addr, 40);
    ram_en = 0;
    cfg(0, 0, 0, 0, 0);

    // random trials
    for (int t = 0; t < 40; t++) begin
      int seg, mode, s, e, r, k;
      int modes[4] = '{0, 1, 3, 4};
      seg = 1 + int'($urandom_range(0, 2));
      mode = modes[$urandom_range(0, 3)];
      s = int'($urandom_range(0, 900));
      e = s + 1 + int'($urandom_range(0, 60));
      r = int'($urandom_range(0, 4));
      k = int'($urandom_range(0, 200));
      cfg(seg, s, e, r, mode);
      case (mode)
        0: run("R7 rnd", seg, mode, s, e, r, k);
        1: run("R8 rnd", seg, mode, s, e, r, k);
        3: run("R10 rnd", seg, mode, s, e, r, k);
        default: run("R11 rnd", seg, mode, s, e, r, k);
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule